// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single memory requests into the strobe and multiplexed address/data waveforms of a classic 8-bit microcontroller external bus. It runs from the oscillator-rate clock. A machine cycle is six states of two clocks each, so it is twelve clocks long. The block accepts one request per machine cycle. A request is an instruction fetch, a data read or a data write. Each carries a 16-bit address and, for writes, a data byte.

During each cycle the block pulses an address latch enable. It places the low address byte on the shared 8-bit port while that pulse is high and for one clock after it. It holds the high address byte on its own port for the whole cycle. After the address phase the shared port either carries the write byte or is released so that the memory can drive it. The matching active-low strobe (program store enable, read or write) is placed at a fixed clock offset. Read data is captured from the shared port on the last clock of the strobe and returned together with a one-clock done pulse.

Cycles with no request, and fetch cycles, give two latch-enable pulses. Data read and write cycles drop the second pulse, because their strobe spans the middle of the cycle.

Top module: `mbus_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks, phases p0 to p11, where p0 is the first clock after the accepting edge. `req_ready` is high only during p11. A request is taken at the clock edge that ends p11 when `req_valid` is high; at any other edge `req_valid` has no effect.
- R2: `ale` is high in p0 and p1 of every cycle. It is high again in p6 and p7 in fetch and idle cycles, and stays low for p2 to p11 in data read and write cycles.
- R3: In a fetch cycle `psen_n` is low in p3 to p5 only. The byte on `ad_in` at the end of p5 appears on `rdata` in p6.
- R4: In a read cycle `rd_n` is low in p5 to p10 only. The byte on `ad_in` at the end of p10 appears on `rdata` in p11.
- R5: In a write cycle `wr_n` is low in p5 to p10 only. `ad_out` carries the request's write byte with `ad_oe` high from p3 through p11, so the byte is set up before the strobe falls and held one clock after it rises.
- R6: `ad_oe` is high and `ad_out` equals the address bits 7:0 in p0 to p2 of every cycle. `ad_oe` is low in p3 to p11 of fetch, read and idle cycles.
- R7: `addr_hi` equals address bits 15:8 of the latest accepted request for all twelve clocks of a cycle. It changes only at the edge that ends p11. Request inputs that change after acceptance do not alter the cycle.
- R8: At most one of `psen_n`, `rd_n` and `wr_n` is low at any clock. `ad_oe` is low whenever `psen_n` or `rd_n` is low.
- R9: While `rst` is high, `ale`, `psen_n`, `rd_n` and `wr_n` are high, and `req_ready` and `done` are low. A request held across the release of reset is not taken, and the first cycle after reset is idle.
- R10: `req_kind` encoding: 0 is fetch, 1 is read, 2 is write, 3 is idle. An accepted kind-3 request gives a cycle with no strobe but still latches its address.
- R11: `done` is a single-clock pulse: in p6 of a fetch cycle, and in p11 of a read or write cycle. Idle cycles give no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind: 0 fetch, 1 read, 2 write, 3 idle |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | High in the last clock of a machine cycle |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared port output: low address, then write data |
| ad_oe | output | 1 | Output enable for the shared port |
| ad_in | input | 8 | Shared port input from memory |
| addr_hi | output | 8 | High address byte |
| rdata | output | 8 | Captured fetch or read byte |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest behaviour to reach from the ports is a request that arrives outside the cycle boundary, or across the release of reset. In both cases the request must vanish without a trace. The stimulus raises `req_valid` while reset is held and keeps it high over the first edge after release. It also pulses a read request in the middle of an idle cycle, then records the full strobe timeline of that cycle and of the next one to show that no strobe appears. Capture timing is covered by a memory model that drives the true byte only while a strobe is low and the inverted byte otherwise. A capture taken one clock early or late therefore returns the wrong value.

// File: rtl/mbus_seq_pkg.sv
package mbus_seq_pkg;

    // Request kind; encoding is visible on the req_kind port.
    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_IDLE  = 2'd3
    } op_e;

    // Levels for the bus pins during one clock.
    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
        logic oe;
        logic data_sel;
    } strobe_t;

    localparam strobe_t STROBE_RESET = '{
        ale: 1'b1, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0, data_sel: 1'b0
    };

endpackage

// File: rtl/mbus_seq_phase.sv
module mbus_seq_phase #(
    parameter int CYC_LEN = 12,
    parameter int PH_W    = 4
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_q,
    output logic [PH_W-1:0] phase_d,
    output logic            last_q
);

    localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            last;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.ph   = (cnt_q.ph == LAST) ? '0 : cnt_q.ph + PH_W'(1);
        cnt_d.last = (cnt_d.ph == LAST);
    end

    // Reset parks on the last phase with ready low, so the first cycle
    // after release starts at p0 and cannot take a request.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '{ph: LAST, last: 1'b0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign phase_q = cnt_q.ph;
    assign phase_d = cnt_d.ph;
    assign last_q  = cnt_q.last;

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);

    // R1
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        last_q |=> !last_q);

endmodule

// File: rtl/mbus_seq_strobe.sv
module mbus_seq_strobe
    import mbus_seq_pkg::*;
#(
    parameter int OSC_PER_STATE  = 2,
    parameter int STATES_PER_CYC = 6,
    parameter int PH_W           = 4
) (
    input  logic [PH_W-1:0] phase,
    input  op_e             op,
    output strobe_t         str
);

    localparam int CYC_LEN = OSC_PER_STATE * STATES_PER_CYC;
    localparam int HALF    = CYC_LEN / 2;
    localparam int ALE_LEN = OSC_PER_STATE;

    localparam logic [PH_W-1:0] ALE_A_END = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0] ALE_B_BEG = PH_W'(HALF);
    localparam logic [PH_W-1:0] ALE_B_END = PH_W'(HALF + ALE_LEN);
    localparam logic [PH_W-1:0] ADR_END   = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0] PS_BEG    = PH_W'(ALE_LEN + 1);
    localparam logic [PH_W-1:0] PS_END    = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] XS_BEG    = PH_W'(ALE_LEN + 3);
    localparam logic [PH_W-1:0] XS_END    = PH_W'(CYC_LEN - 2);
    localparam logic [PH_W-1:0] WD_BEG    = PH_W'(ALE_LEN + 1);

    logic is_data;
    logic in_xfer;

    always_comb begin
        is_data = (op == OP_READ) || (op == OP_WRITE);
        in_xfer = (phase >= XS_BEG) && (phase <= XS_END);

        str.ale = (phase < ALE_A_END)
               || (!is_data && (phase >= ALE_B_BEG) && (phase < ALE_B_END));
        str.psen_n   = !((op == OP_FETCH) && (phase >= PS_BEG) && (phase <= PS_END));
        str.rd_n     = !((op == OP_READ) && in_xfer);
        str.wr_n     = !((op == OP_WRITE) && in_xfer);
        str.data_sel = (op == OP_WRITE) && (phase >= WD_BEG);
        str.oe       = (phase <= ADR_END) || str.data_sel;
    end

endmodule

// File: rtl/mbus_seq_capture.sv
module mbus_seq_capture
    import mbus_seq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PH_W      = 4,
    parameter int FETCH_LAT = 5,
    parameter int XFER_LAT  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase_q,
    input  op_e               op_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    localparam logic [PH_W-1:0] F_PH = PH_W'(FETCH_LAT);
    localparam logic [PH_W-1:0] X_PH = PH_W'(XFER_LAT);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              done;
    } cap_t;

    cap_t cap_d, cap_q;
    logic grab;

    always_comb begin
        cap_d = cap_q;
        grab  = ((op_q == OP_FETCH) && (phase_q == F_PH))
             || ((op_q == OP_READ)  && (phase_q == X_PH));
        if (grab) begin
            cap_d.rdata = ad_in;
        end
        cap_d.done = grab || ((op_q == OP_WRITE) && (phase_q == X_PH));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata = cap_q.rdata;
    assign done  = cap_q.done;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_seq_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 8,
    parameter int OSC_PER_STATE  = 2,
    parameter int STATES_PER_CYC = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);

    localparam int CYC_LEN   = OSC_PER_STATE * STATES_PER_CYC;
    localparam int PH_W      = $clog2(CYC_LEN);
    localparam int FETCH_LAT = CYC_LEN / 2 - 1;
    localparam int XFER_LAT  = CYC_LEN - 2;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        strobe_t           str;
        logic [DATA_W-1:0] ad;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_d;
    logic            last_q;
    logic            accept;
    op_e             op_nxt;
    strobe_t         str_nxt;

    mbus_seq_phase #(
        .CYC_LEN (CYC_LEN),
        .PH_W    (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .last_q  (last_q)
    );

    // The kind of the coming cycle is chosen only at the boundary.
    assign accept = req_valid && last_q;
    assign op_nxt = last_q ? (accept ? op_e'(req_kind) : OP_IDLE) : seq_q.op;

    mbus_seq_strobe #(
        .OSC_PER_STATE  (OSC_PER_STATE),
        .STATES_PER_CYC (STATES_PER_CYC),
        .PH_W           (PH_W)
    ) u_strobe (
        .phase (phase_d),
        .op    (op_nxt),
        .str   (str_nxt)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.op = op_nxt;
        if (accept) begin
            seq_d.addr  = req_addr;
            seq_d.wdata = req_wdata;
        end
        seq_d.str = str_nxt;
        seq_d.ad  = str_nxt.data_sel ? seq_d.wdata : seq_d.addr[DATA_W-1:0];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            seq_q <= '{op: OP_IDLE, addr: '0, wdata: '0, str: STROBE_RESET, ad: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    mbus_seq_capture #(
        .DATA_W    (DATA_W),
        .PH_W      (PH_W),
        .FETCH_LAT (FETCH_LAT),
        .XFER_LAT  (XFER_LAT)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .op_q    (seq_q.op),
        .ad_in   (ad_in),
        .rdata   (rdata),
        .done    (done)
    );

    assign req_ready = last_q;
    assign ale       = seq_q.str.ale;
    assign psen_n    = seq_q.str.psen_n;
    assign rd_n      = seq_q.str.rd_n;
    assign wr_n      = seq_q.str.wr_n;
    assign ad_oe     = seq_q.str.oe;
    assign ad_out    = seq_q.ad;
    assign addr_hi   = seq_q.addr[ADDR_W-1:DATA_W];

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    // R8
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !ad_oe);

    // R7
    addr_hi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(addr_hi));

    // R2
    ale_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> (ale ##1 !ale));

    // R2
    ale_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !ale);

    // R3
    psen_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> (!psen_n ##1 !psen_n ##1 psen_n));

    // R4
    rd_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7)));

    // R5
    wr_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (!$past(wr_n, 6) && $past(wr_n, 7)));

    // R5
    wr_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

endmodule

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic        vld;
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  mem;
    } vec_t;

    // kind: 0 fetch, 1 read, 2 write, 3 idle
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 2'd0, 16'h1234, 8'h00, 8'hA5},
        '{1'b1, 2'd1, 16'hBEEF, 8'h11, 8'h3C},
        '{1'b1, 2'd2, 16'h00FF, 8'h5A, 8'h77},
        '{1'b1, 2'd2, 16'hFF00, 8'hC3, 8'h01},
        '{1'b0, 2'd1, 16'h4444, 8'h22, 8'h99},
        '{1'b1, 2'd1, 16'h8001, 8'h00, 8'h00},
        '{1'b1, 2'd3, 16'h6A6A, 8'h33, 8'h44},
        '{1'b1, 2'd0, 16'hFFFF, 8'h00, 8'hFF},
        '{1'b1, 2'd1, 16'h0102, 8'h00, 8'hE7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd3;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        ale, psen_n, rd_n, wr_n, ad_oe, done;
    logic [7:0]  ad_out, ad_in, addr_hi, rdata;
    logic [7:0]  cur_mem = 8'h00;
    logic [15:0] exp_addr = '0;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: true byte only while a read-type strobe is low.
    assign ad_in = (!psen_n || !rd_n) ? cur_mem : ~cur_mem;

    mbus_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .ale       (ale),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ad_in     (ad_in),
        .addr_hi   (addr_hi),
        .rdata     (rdata),
        .done      (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input vec_t v, input bit inject);
        logic [11:0] m_ale, m_psen, m_rd, m_wr, m_oe, m_done, m_rdy;
        logic [11:0] e_ale, e_psen, e_rd, e_wr, e_oe, e_done;
        logic [7:0]  rd6, rd11;
        bit          hi_bad, lo_bad, wd_bad, excl_bad;
        logic [1:0]  ek;
        bit          isf, isr, isw;
        hi_bad = 0; lo_bad = 0; wd_bad = 0; excl_bad = 0;
        rd6 = '0; rd11 = '0;
        while (!req_ready) @(negedge clk);
        req_valid = v.vld;
        req_kind  = v.kind;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        cur_mem   = v.mem;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_addr  = ~v.addr;
        req_wdata = ~v.wdata;
        if (v.vld) exp_addr = v.addr;
        ek  = v.vld ? v.kind : 2'd3;
        isf = (ek == 2'd0);
        isr = (ek == 2'd1);
        isw = (ek == 2'd2);
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            m_ale[p]  = ale;
            m_psen[p] = !psen_n;
            m_rd[p]   = !rd_n;
            m_wr[p]   = !wr_n;
            m_oe[p]   = ad_oe;
            m_done[p] = done;
            m_rdy[p]  = req_ready;
            if (addr_hi !== exp_addr[15:8]) hi_bad = 1;
            if (p <= 2 && ad_out !== exp_addr[7:0]) lo_bad = 1;
            if (isw && p >= 3 && ad_out !== v.wdata) wd_bad = 1;
            if ($countones({!psen_n, !rd_n, !wr_n}) > 1) excl_bad = 1;
            if (p == 6) rd6 = rdata;
            if (p == 11) rd11 = rdata;
            if (inject && p == 3) begin
                req_valid = 1'b1;
                req_kind  = 2'd1;
            end
            if (inject && p == 4) req_valid = 1'b0;
        end
        e_ale  = (isr || isw) ? 12'h003 : 12'h0C3;
        e_psen = isf ? 12'h038 : 12'h000;
        e_rd   = isr ? 12'h7E0 : 12'h000;
        e_wr   = isw ? 12'h7E0 : 12'h000;
        e_oe   = isw ? 12'hFFF : 12'h007;
        e_done = isf ? 12'h040 : ((isr || isw) ? 12'h800 : 12'h000);
        chk(m_rdy == 12'h800, "R1 ready", {20'h0, m_rdy}, 32'h800);
        if (inject) chk(m_rd == 12'h000, "R1 mid-cycle request", {20'h0, m_rd}, 0);
        chk(m_ale == e_ale, "R2 ale", {20'h0, m_ale}, {20'h0, e_ale});
        chk(m_psen == e_psen, "R3 psen", {20'h0, m_psen}, {20'h0, e_psen});
        chk(m_rd == e_rd, "R4 rd", {20'h0, m_rd}, {20'h0, e_rd});
        chk(m_wr == e_wr, "R5 wr", {20'h0, m_wr}, {20'h0, e_wr});
        chk(m_oe == e_oe, "R6 oe", {20'h0, m_oe}, {20'h0, e_oe});
        chk(!lo_bad, "R6 low address", 32'(lo_bad), 0);
        chk(!hi_bad, "R7 high address", 32'(hi_bad), 0);
        chk(!excl_bad, "R8 exclusive strobes", 32'(excl_bad), 0);
        chk(m_done == e_done, "R11 done", {20'h0, m_done}, {20'h0, e_done});
        if (isw) chk(!wd_bad, "R5 write data", 32'(wd_bad), 0);
        if (isf) chk(rd6 === v.mem, "R3 fetch data", {24'h0, rd6}, {24'h0, v.mem});
        if (isr) chk(rd11 === v.mem, "R4 read data", {24'h0, rd11}, {24'h0, v.mem});
        if (v.vld && v.kind == 2'd3)
            chk((m_psen | m_rd | m_wr) == 12'h000, "R10 idle kind",
                {20'h0, m_psen | m_rd | m_wr}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [11:0] r_rd, r_ale;
        bit          r_hi_bad;
        // Reset state with a request held across reset.
        req_valid = 1'b1;
        req_kind  = 2'd1;
        req_addr  = 16'hABCD;
        repeat (3) @(negedge clk);
        chk(ale === 1'b1, "R9 ale in reset", 32'(ale), 1);
        chk({psen_n, rd_n, wr_n} === 3'b111, "R9 strobes in reset",
            32'({psen_n, rd_n, wr_n}), 7);
        chk(req_ready === 1'b0, "R9 ready in reset", 32'(req_ready), 0);
        chk(done === 1'b0, "R9 done in reset", 32'(done), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        r_hi_bad = 0;
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            r_rd[p]  = !rd_n;
            r_ale[p] = ale;
            if (addr_hi !== 8'h00) r_hi_bad = 1;
        end
        chk(r_rd == 12'h000, "R9 first cycle idle", {20'h0, r_rd}, 0);
        chk(r_ale == 12'h0C3, "R9 first cycle ale", {20'h0, r_ale}, 32'h0C3);
        chk(!r_hi_bad, "R9 address not taken", 32'(r_hi_bad), 0);

        // Table of requests, back to back.
        for (int i = 0; i < NVEC; i++) begin
            run_cycle(VECS[i], 1'b0);
        end

        // Request pulsed in mid-cycle must be ignored (R1).
        run_cycle('{1'b0, 2'd3, 16'h0000, 8'h00, 8'h12}, 1'b1);
        run_cycle('{1'b0, 2'd3, 16'h0000, 8'h00, 8'h12}, 1'b0);
        // Closing read after the idle pair.
        run_cycle('{1'b1, 2'd1, 16'h7F80, 8'h00, 8'h6D}, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule